// File: doc/BRIEF.md
# Video Window Crop and Decimation

This block cuts a rectangular output window out of a stream of already scaled video pixels. It counts lines from each field start and pixels from each line start. It forwards a pixel, one cycle later, only when four conditions all hold: the pixel lies inside the programmed horizontal span, the line lies inside the vertical span and is kept by even line dropping, the field type is enabled, and the frame is kept by temporal thinning.

Vertical compression never interpolates. When fewer output lines than input lines are requested, whole lines are dropped and the kept ones are spread evenly. If the vertical span runs past the last line of the selected line standard, it is cut back automatically. Temporal thinning keeps a programmed number of frames out of every 3000, also spread evenly. The window settings are captured at every field start, so a write in the middle of a field takes effect at the next field.

Top module: `vwin_crop`

## Requirements
- R1: After reset, and until the first field start, `pix_out_vld` and `line_act` stay low whatever pixels and line starts arrive.
- R2: The field mode captured at field start (with `field_odd` sampled in the same cycle) gates the whole field: 2'b00 passes both field types, 2'b01 passes only even fields (`field_odd`=0), 2'b10 passes only odd fields, and 2'b11 passes none.
- R3: Lines are numbered from 1 at the first line start after a field start. A line n is inside the vertical span when `cfg_vbeg` <= n < `cfg_vbeg` + `cfg_vlin_in`.
- R4: No line number above the standard's last line is ever active. The last line is 312 when `std_50hz`=1 and 262 when `std_50hz`=0, sampled at field start.
- R5: The k-th line inside the vertical span (k from 1) is kept exactly when floor(k*O/I) > floor((k-1)*O/I), with I = `cfg_vlin_in` and O = min(`cfg_vlin_out`, I). Lines are dropped and never blended.
- R6: Pixel p of a line (p counts valid pixels from 0 after the line start) is output only when `cfg_hbeg` <= p < `cfg_hbeg` + `cfg_hlen` and p < `cfg_npix`.
- R7: An output pixel appears one cycle after its input cycle and carries the input data unchanged. `pix_out_vld` is low in any cycle that follows a cycle with no input pixel.
- R8: With thinning enabled, a frame begins at a field start with `field_odd`=1. The f-th frame since enabling (f from 1) is kept exactly when floor(f*K/3000) > floor((f-1)*K/3000), with K = min(`cfg_tdec_keep`, 3000). Both fields of a frame share its decision.
- R9: With thinning disabled, every frame is kept. Disabling restarts the sequence, so that the next enabled frame counts as f = 1.
- R10: Window, span, field mode and standard settings changed after a field start have no effect until the next field start.
- R11: `line_act` is high from the first output slot of a line that passes R2, R3, R4, R5 and R8. It stays high until the output slot after the next line or field start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | DW | Input pixel data |
| pix_vld | input | 1 | Input pixel present (ignored in strobe cycles) |
| line_start | input | 1 | Pulse before the first pixel of a line |
| field_start | input | 1 | Pulse at the start of a field |
| field_odd | input | 1 | Field type, sampled with field_start (1 = odd) |
| std_50hz | input | 1 | Line standard: 1 = 312 lines/field, 0 = 262 |
| cfg_vbeg | input | LW | First active line number |
| cfg_vlin_in | input | LW | Number of lines in the vertical span |
| cfg_vlin_out | input | LW | Number of lines to keep from the span |
| cfg_hbeg | input | PW | First output pixel index |
| cfg_hlen | input | PW | Number of output pixels per line |
| cfg_npix | input | PW | Active pixels per full line |
| cfg_fmode | input | 2 | Field enable mode |
| cfg_tdec_en | input | 1 | Temporal thinning enable |
| cfg_tdec_keep | input | TW | Frames kept per 3000 |
| pix_out | output | DW | Output pixel data |
| pix_out_vld | output | 1 | Output pixel valid |
| line_act | output | 1 | Current output line is active |

## Verification
A wrong line accumulator shows up at the ports within one field. The set of kept lines shifts, so some line either loses all its pixels or gains pixels it should not have, and the total kept count no longer equals the requested output count. A wrong frame accumulator only shows in which frames carry pixels, which can take many frames to diverge. The bench therefore walks a full 3000-frame interval and checks every frame's decision as well as the total. A horizontal counter fault shows on the first line of an enabled field, as valid strobes shifted against the span edges. A faulty capture of the settings shows as a mid-field change leaking into the current field.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

  typedef enum logic [1:0] {
    FM_BOTH = 2'b00,
    FM_EVEN = 2'b01,
    FM_ODD  = 2'b10,
    FM_OFF  = 2'b11
  } fmode_e;

  function automatic logic field_pass(fmode_e m, logic odd);
    case (m)
      FM_BOTH: return 1'b1;
      FM_EVEN: return ~odd;
      FM_ODD:  return odd;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vwin_vert.sv
module vwin_vert #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          field_start,
  input  logic          line_start,
  input  logic [LW-1:0] vbeg,
  input  logic [LW:0]   vend,
  input  logic [LW-1:0] vin,
  input  logic [LW-1:0] vout,
  output logic          line_keep
);
  localparam logic [LW:0] CNT_MAX = '1;

  logic [LW:0]   line_cnt;
  logic [LW:0]   acc;
  logic [LW:0]   nxt;
  logic          in_span;
  logic [LW+1:0] sum;

  assign nxt     = (line_cnt == CNT_MAX) ? line_cnt : line_cnt + 1'b1;
  assign in_span = (nxt >= {1'b0, vbeg}) && (nxt < vend);
  assign sum     = {1'b0, acc} + {2'b00, vout};

  always_ff @(posedge clk) begin
    if (rst || field_start) begin
      line_cnt  <= '0;
      acc       <= '0;
      line_keep <= 1'b0;
    end else if (line_start) begin
      line_cnt <= nxt;
      if (in_span) begin
        if (sum >= {2'b00, vin}) begin
          line_keep <= 1'b1;
          acc       <= (LW+1)'(sum - {2'b00, vin});
        end else begin
          line_keep <= 1'b0;
          acc       <= (LW+1)'(sum);
        end
      end else begin
        line_keep <= 1'b0;
      end
    end
  end

  AST_LINE_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (acc == '0) || (acc < {1'b0, vin})); // R5

  AST_KEEP_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
    line_keep |-> ((line_cnt >= {1'b0, vbeg}) && (line_cnt < vend))); // R3

endmodule

// File: rtl/vwin_horz.sv
module vwin_horz #(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          pix_ok,
  input  logic [PW-1:0] hbeg,
  input  logic [PW:0]   hend,
  output logic          hit
);
  localparam logic [PW:0] POS_MAX = '1;

  logic [PW:0] hpos;

  assign hit = pix_ok && (hpos >= {1'b0, hbeg}) && (hpos < hend);

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      hpos <= '0;
    end else if (pix_ok && hpos != POS_MAX) begin
      hpos <= hpos + 1'b1;
    end
  end

endmodule

// File: rtl/vwin_frame.sv
module vwin_frame #(
  parameter int INTERVAL = 3000,
  parameter int TW       = $clog2(INTERVAL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          en,
  input  logic [TW-1:0] keep,
  output logic          frame_ok
);
  localparam logic [TW:0] IV = (TW+1)'(INTERVAL);

  logic [TW-1:0] acc;
  logic [TW:0]   keep_eff;
  logic [TW:0]   sum;

  assign keep_eff = ({1'b0, keep} > IV) ? IV : {1'b0, keep};
  assign sum      = {1'b0, acc} + keep_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      frame_ok <= 1'b1;
    end else if (!en) begin
      acc <= '0;
      if (frame_start) frame_ok <= 1'b1;
    end else if (frame_start) begin
      if (sum >= IV) begin
        frame_ok <= 1'b1;
        acc      <= TW'(sum - IV);
      end else begin
        frame_ok <= 1'b0;
        acc      <= TW'(sum);
      end
    end
  end

  AST_FRAME_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc} < IV); // R8

  AST_TDEC_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !en) |=> frame_ok); // R9

endmodule

// File: rtl/vwin_crop.sv
module vwin_crop
  import vwin_pkg::*;
#(
  parameter int DW            = 8,
  parameter int LW            = 9,
  parameter int PW            = 11,
  parameter int TDEC_INTERVAL = 3000,
  parameter int LINES_50      = 312,
  parameter int LINES_60      = 262,
  parameter int TW            = $clog2(TDEC_INTERVAL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pix_in,
  input  logic          pix_vld,
  input  logic          line_start,
  input  logic          field_start,
  input  logic          field_odd,
  input  logic          std_50hz,
  input  logic [LW-1:0] cfg_vbeg,
  input  logic [LW-1:0] cfg_vlin_in,
  input  logic [LW-1:0] cfg_vlin_out,
  input  logic [PW-1:0] cfg_hbeg,
  input  logic [PW-1:0] cfg_hlen,
  input  logic [PW-1:0] cfg_npix,
  input  logic [1:0]    cfg_fmode,
  input  logic          cfg_tdec_en,
  input  logic [TW-1:0] cfg_tdec_keep,
  output logic [DW-1:0] pix_out,
  output logic          pix_out_vld,
  output logic          line_act
);
  localparam logic [LW:0] VLIM_50 = (LW+1)'(LINES_50 + 1);
  localparam logic [LW:0] VLIM_60 = (LW+1)'(LINES_60 + 1);

  logic          pix_ok;
  logic          frame_start;
  logic [LW:0]   vend_raw;
  logic [LW:0]   vlim;
  logic [PW:0]   hend_raw;

  logic [LW-1:0] vbeg_s, vin_s, vout_s;
  logic [LW:0]   vend_s;
  logic [PW-1:0] hbeg_s;
  logic [PW:0]   hend_s;
  logic          field_ok;

  logic          line_keep;
  logic          hit;
  logic          frame_ok;

  assign pix_ok      = pix_vld & ~line_start & ~field_start;
  assign frame_start = field_start & field_odd;
  assign vend_raw    = {1'b0, cfg_vbeg} + {1'b0, cfg_vlin_in};
  assign vlim        = std_50hz ? VLIM_50 : VLIM_60;
  assign hend_raw    = {1'b0, cfg_hbeg} + {1'b0, cfg_hlen};

  // Settings are captured once per field
  always_ff @(posedge clk) begin
    if (rst) begin
      vbeg_s   <= '0;
      vin_s    <= '0;
      vout_s   <= '0;
      vend_s   <= '0;
      hbeg_s   <= '0;
      hend_s   <= '0;
      field_ok <= 1'b0;
    end else if (field_start) begin
      vbeg_s   <= cfg_vbeg;
      vin_s    <= cfg_vlin_in;
      vout_s   <= (cfg_vlin_out > cfg_vlin_in) ? cfg_vlin_in : cfg_vlin_out;
      vend_s   <= (vend_raw > vlim) ? vlim : vend_raw;
      hbeg_s   <= cfg_hbeg;
      hend_s   <= (hend_raw > {1'b0, cfg_npix}) ? {1'b0, cfg_npix} : hend_raw;
      field_ok <= field_pass(fmode_e'(cfg_fmode), field_odd);
    end
  end

  vwin_vert #(.LW(LW)) u_vert (
    .clk        (clk),
    .rst        (rst),
    .field_start(field_start),
    .line_start (line_start),
    .vbeg       (vbeg_s),
    .vend       (vend_s),
    .vin        (vin_s),
    .vout       (vout_s),
    .line_keep  (line_keep)
  );

  vwin_horz #(.PW(PW)) u_horz (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .pix_ok    (pix_ok),
    .hbeg      (hbeg_s),
    .hend      (hend_s),
    .hit       (hit)
  );

  vwin_frame #(.INTERVAL(TDEC_INTERVAL), .TW(TW)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .en         (cfg_tdec_en),
    .keep       (cfg_tdec_keep),
    .frame_ok   (frame_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out     <= '0;
      pix_out_vld <= 1'b0;
      line_act    <= 1'b0;
    end else begin
      if (pix_ok) pix_out <= pix_in;
      pix_out_vld <= hit & line_keep & field_ok & frame_ok;
      line_act    <= line_keep & field_ok & frame_ok;
    end
  end

  AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    pix_out_vld |-> $past(pix_vld)); // R7

  AST_OUT_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    pix_out_vld |-> line_act); // R11

endmodule

// File: tb/vwin_crop_bench.sv
module vwin_crop_bench;
  localparam int DW = 8, LW = 9, PW = 11, TW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] pix_in = '0;
  logic          pix_vld = 1'b0, line_start = 1'b0, field_start = 1'b0, field_odd = 1'b0;
  logic          std_50hz = 1'b1;
  logic [LW-1:0] cfg_vbeg = '0, cfg_vlin_in = '0, cfg_vlin_out = '0;
  logic [PW-1:0] cfg_hbeg = '0, cfg_hlen = '0, cfg_npix = 11'd32;
  logic [1:0]    cfg_fmode = 2'b00;
  logic          cfg_tdec_en = 1'b0;
  logic [TW-1:0] cfg_tdec_keep = '0;
  logic [DW-1:0] pix_out;
  logic          pix_out_vld, line_act;

  always #2 clk = ~clk;

  vwin_crop u_vwin_crop (
    .clk(clk), .rst(rst), .pix_in(pix_in), .pix_vld(pix_vld),
    .line_start(line_start), .field_start(field_start), .field_odd(field_odd),
    .std_50hz(std_50hz), .cfg_vbeg(cfg_vbeg), .cfg_vlin_in(cfg_vlin_in),
    .cfg_vlin_out(cfg_vlin_out), .cfg_hbeg(cfg_hbeg), .cfg_hlen(cfg_hlen),
    .cfg_npix(cfg_npix), .cfg_fmode(cfg_fmode), .cfg_tdec_en(cfg_tdec_en),
    .cfg_tdec_keep(cfg_tdec_keep), .pix_out(pix_out), .pix_out_vld(pix_out_vld),
    .line_act(line_act)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  // expectation state taken at field start
  int s_vb = 0, s_vi = 0, s_vo = 0, s_hb = 0, s_hl = 0, s_np = 0, s_std = 1;
  bit fe = 0, fk = 1;
  int line_n = 0, fidx = 0, kept_frames = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_line(int n);
    int first, lim, k, oe;
    first = (s_vb < 1) ? 1 : s_vb;
    lim = s_std ? 312 : 262;
    if (n < first || n >= s_vb + s_vi || n > lim) return 0;
    k = n - first + 1;
    oe = (s_vo > s_vi) ? s_vi : s_vo;
    return (k * oe) / s_vi > ((k - 1) * oe) / s_vi;
  endfunction

  function automatic bit exp_frame(int f, int keep);
    int kk;
    kk = (keep > 3000) ? 3000 : keep;
    return (f * kk) / 3000 > ((f - 1) * kk) / 3000;
  endfunction

  task automatic set_tdec(bit en, int keep);
    @(negedge clk);
    cfg_tdec_en = en;
    cfg_tdec_keep = TW'(keep);
    if (!en) fidx = 0;
  endtask

  task automatic do_field(bit odd);
    @(negedge clk);
    field_start = 1'b1;
    field_odd = odd;
    s_vb = cfg_vbeg; s_vi = cfg_vlin_in; s_vo = cfg_vlin_out;
    s_hb = cfg_hbeg; s_hl = cfg_hlen; s_np = cfg_npix; s_std = std_50hz;
    fe = (cfg_fmode == 2'b00) || (cfg_fmode == 2'b01 && !odd) || (cfg_fmode == 2'b10 && odd);
    if (odd) begin
      if (!cfg_tdec_en) fk = 1;
      else begin
        fidx++;
        fk = exp_frame(fidx, int'(cfg_tdec_keep));
      end
    end
    line_n = 0;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  // one line of npx pixels; returns how many pixels came out
  task automatic do_line(int npx, string req, output int nout);
    bit lk, ev;
    int d;
    nout = 0;
    @(negedge clk);
    line_start = 1'b1;
    line_n++;
    lk = exp_line(line_n) && fe && fk;
    @(negedge clk);
    line_start = 1'b0;
    for (int p = 0; p < npx; p++) begin
      d = (line_n * 7 + p * 3 + 1) & 255;
      pix_vld = 1'b1;
      pix_in = DW'(d);
      @(negedge clk);
      pix_vld = 1'b0;
      ev = lk && p >= s_hb && p < s_hb + s_hl && p < s_np;
      chk(pix_out_vld == ev, req, pix_out_vld, ev);
      if (ev) begin
        chk(pix_out == DW'(d), "R7", pix_out, d);
        nout++;
      end
      if (p == 0) chk(line_act == lk, "R11", line_act, lk);
    end
    @(negedge clk);
    chk(pix_out_vld == 1'b0, "R7", pix_out_vld, 0);
  endtask

  task automatic set_win(int vb, int vi, int vo, int hb, int hl, int np);
    @(negedge clk);
    cfg_vbeg = LW'(vb); cfg_vlin_in = LW'(vi); cfg_vlin_out = LW'(vo);
    cfg_hbeg = PW'(hb); cfg_hlen = PW'(hl); cfg_npix = PW'(np);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, tot;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: silent before first field start
    chk(pix_out_vld == 0, "R1", pix_out_vld, 0);
    chk(line_act == 0, "R1", line_act, 0);
    set_win(1, 4, 4, 0, 8, 32);
    do_line(6, "R1", n);
    do_line(6, "R1", n);

    // R2/R3/R5/R6: sweep field modes and field types
    set_win(2, 5, 3, 3, 4, 32);
    for (int m = 0; m < 4; m++) begin
      for (int od = 0; od < 2; od++) begin
        cfg_fmode = 2'(m);
        do_field(od[0]);
        tot = 0;
        for (int l = 0; l < 8; l++) begin
          do_line(10, "R2", n);
          tot += n;
        end
        // lines 3,5,6 kept, 4 pixels each when enabled
        chk(tot == (fe ? 12 : 0), "R5", tot, fe ? 12 : 0);
      end
    end

    // R5: every output count against a span of 6
    cfg_fmode = 2'b00;
    for (int vo = 0; vo < 8; vo++) begin
      set_win(1, 6, vo, 0, 2, 32);
      do_field(1'b1);
      tot = 0;
      for (int l = 0; l < 8; l++) begin
        do_line(2, "R5", n);
        tot += n;
      end
      chk(tot == 2 * ((vo > 6) ? 6 : vo), "R5", tot, 2 * ((vo > 6) ? 6 : vo));
    end

    // R6: right edge limited by the active pixel count
    set_win(1, 1, 1, 28, 10, 32);
    do_field(1'b1);
    do_line(36, "R6", n);
    chk(n == 4, "R6", n, 4);

    // R4: clamp at the standard's last line
    std_50hz = 1'b0;
    set_win(258, 20, 20, 0, 1, 32);
    do_field(1'b1);
    tot = 0;
    for (int l = 0; l < 266; l++) begin
      do_line(1, "R4", n);
      tot += n;
    end
    chk(tot == 5, "R4", tot, 5);
    std_50hz = 1'b1;
    set_win(308, 20, 20, 0, 1, 32);
    do_field(1'b1);
    tot = 0;
    for (int l = 0; l < 316; l++) begin
      do_line(1, "R4", n);
      tot += n;
    end
    chk(tot == 5, "R4", tot, 5);

    // R10: changes inside a field wait for the next field
    set_win(1, 2, 2, 0, 2, 32);
    do_field(1'b1);
    @(negedge clk);
    cfg_hbeg = 11'd5;
    cfg_fmode = 2'b11;
    do_line(8, "R10", n);
    chk(n == 2, "R10", n, 2);
    do_field(1'b1);
    do_line(8, "R10", n);
    chk(n == 0, "R10", n, 0);
    cfg_fmode = 2'b00;

    // R9: thinning off keeps all frames; R8: both fields share decision
    set_win(1, 1, 1, 0, 2, 32);
    set_tdec(0, 0);
    for (int f = 0; f < 3; f++) begin
      do_field(1'b1);
      do_line(2, "R9", n);
      chk(n == 2, "R9", n, 2);
    end
    set_tdec(1, 1500);
    for (int f = 0; f < 6; f++) begin
      do_field(1'b1);
      do_line(2, "R8", n);
      do_field(1'b0);
      do_line(2, "R8", n);
    end
    set_tdec(0, 1500);
    set_tdec(1, 1500);
    do_field(1'b1);
    do_line(2, "R9", n);
    chk(n == 0, "R9", n, 0);

    // R8: full interval of 3000 frames keeping 7
    set_win(1, 1, 1, 0, 1, 32);
    set_tdec(0, 7);
    set_tdec(1, 7);
    kept_frames = 0;
    for (int f = 0; f < 3000; f++) begin
      do_field(1'b1);
      do_line(1, "R8", n);
      kept_frames += n;
      do_field(1'b0);
    end
    chk(kept_frames == 7, "R8", kept_frames, 7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule